// File: doc/BRIEF.md
# Flexible Multilevel Access Table Walker

This block finds the execute/write/read permission for a physical address. It starts from a pointer word and a region shift S, both chosen by a separate region matcher, and from there walks a table in memory whose shape software defines. Each word it visits carries a 4-bit type code and a NAPOT-coded index width T. From these the walker decides one of four things: the word is itself a leaf permission, it points to a further table of pointer words, it points to a last-level table of packed permission entries, or it is malformed. The start word and every fetched pointer word are decoded the same way.

Memory is read one doubleword at a time. Each read is a valid/ready request carrying a byte address, and only one request is ever outstanding. A walk starts when a request is accepted on the start handshake. It ends with a single-cycle result pulse that carries either a 3-bit permission or a fault. Before each step the walker tracks the bit position H, which marks the low end of the address bits used so far. H starts at 12+S and drops by the number of index bits each pointer level consumes.

Top module: `mlat_walker`

## Requirements
- R1: After reset `start_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0. A walk is accepted when `start_valid` and `start_ready` are both high at a clock edge. `start_ready` stays low from then until the result pulse.
- R2: In every word, bits 3:0 give the type. T is the number of zero bits counted upward from bit 4 below the lowest set bit of bits 63:4. H begins at 12+S. The walk faults if bits 63:4 are all zero, if 5+T exceeds PAW, or if H exceeds PAW.
- R3: Types 0, 1, 3, 4, 5 and 7 are leaves. They report `done_perm` equal to bits 2:0 of the type, read as {x,w,r}, and issue no memory read.
- R4: For leaf types 1, 3, 4, 5 and 7, word bits PAW-1:5+T must equal the same bits of the physical address; otherwise the walk faults. Type 0 makes no such comparison.
- R5: Type 2 reads the doubleword at B | (PA[H-1:H-T] << 3). B is the word's bits PAW-1:5+T with all lower bits zero. H then becomes H-T, and the fetched word is decoded by the same rules.
- R6: Type 6 uses the index I = PA[H-1:H-N], with N = 6+T. It reads B | ((I >> 4) << 3) and selects the nibble at bits 4k+3:4k, where k = I[3:0]. Nibble values 0, 1, 3, 4, 5 and 7 give a permission equal to the nibble's bits 2:0; any other nibble value faults.
- R7: Type 14 uses N = 7+T. It reads B | ((I >> 5) << 3) and selects the bit pair at 2k+1:2k, where k = I[4:0]. The pair maps 0 to 000, 1 to 001, 2 to 101 and 3 to 111.
- R8: Types 8 to 13 and type 15 fault without any memory read.
- R9: The walk faults without a read if type 2 would leave H-T below 12, or if type 6 or type 14 would leave H-N below 12.
- R10: A walk follows at most MAX_DEPTH type-2 pointers. A type-2 word met after that many pointer fetches faults without a read.
- R11: `mem_req_valid` holds high with a stable `mem_req_addr` until `mem_req_ready`. No new request is made until the response to the previous one has arrived. Every request address is a multiple of 8.
- R12: `done_valid` is high for exactly one cycle per walk. When `done_fault` is 1, `done_perm` is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Walk request present |
| start_ready | output | 1 | Walker idle and able to accept |
| start_ptr | input | 64 | Root pointer or leaf word |
| start_s | input | SW | Region shift S; H starts at 12+S |
| start_pa | input | PAW | Physical address to look up |
| mem_req_valid | output | 1 | Doubleword read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PAW | Byte address of the doubleword |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | The walk faulted |
| done_perm | output | 3 | Permission {x,w,r} |

## Verification
Every cycle, the bound checker confirms that the memory request stays stable while stalled, that requests are aligned, that only one is outstanding, and that no request is made while `start_ready` is high. It also confirms that the result is a clean one-cycle pulse with a zero permission on fault, and that no walk issues more reads than MAX_DEPTH pointers plus one last-level fetch. Some properties need a known table in memory, so only the directed scenarios can show them: the computed fetch addresses, the nibble and pair selection inside a doubleword, the tag comparison on leaves, the 4 KiB limits and the exact point at which the depth limit turns into a fault.

// File: rtl/mlat_pkg.sv
package mlat_pkg;

   localparam int H_FLOOR = 12;

   typedef enum logic [1:0] {
      ACT_FAULT = 2'd0,
      ACT_LEAF  = 2'd1,
      ACT_FETCH = 2'd2
   } mlat_act_e;

   typedef enum logic [1:0] {
      FK_PTR  = 2'd0,
      FK_NIB  = 2'd1,
      FK_PAIR = 2'd2
   } mlat_kind_e;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_EVAL = 2'd1,
      WS_REQ  = 2'd2,
      WS_WAIT = 2'd3
   } mlat_state_e;

   function automatic logic [2:0] pair_to_perm(input logic [1:0] code);
      case (code)
         2'd1:    return 3'b001;
         2'd2:    return 3'b101;
         2'd3:    return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic nib_is_leaf(input logic [3:0] code);
      case (code)
         4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd7: return 1'b1;
         default:                            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/mlat_napot.sv
module mlat_napot #(
   parameter int W  = 60,
   localparam int TW = $clog2(W + 1)
) (
   input  logic [W-1:0]  field,
   output logic          found,
   output logic [TW-1:0] t
);

   always_comb begin
      found = 1'b0;
      t     = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (field[i]) begin
            found = 1'b1;
            t     = TW'(i);
         end
      end
   end

endmodule

// File: rtl/mlat_decode.sv
module mlat_decode
   import mlat_pkg::*;
#(
   parameter int PAW = 40,
   parameter int HW  = 7
) (
   input  logic [63:0]    word,
   input  logic [HW-1:0]  h,
   input  logic [PAW-1:0] pa,
   output mlat_act_e      act,
   output mlat_kind_e     kind,
   output logic [2:0]     perm,
   output logic [PAW-1:0] addr,
   output logic [4:0]     sub,
   output logic [HW-1:0]  h_next
);

   localparam int FW = 60;
   localparam int TW = $clog2(FW + 1);
   localparam logic [PAW-1:0] ONES = {PAW{1'b1}};

   logic          nap_found;
   logic [TW-1:0] nap_t;

   mlat_napot #(.W(FW)) i_napot (
      .field (word[63:4]),
      .found (nap_found),
      .t     (nap_t)
   );

   int unsigned    ti, hi, ni;
   logic [PAW-1:0] w_pa, hi_mask, base, idx;
   logic           tag_eq;

   always_comb begin
      ti      = 32'(nap_t);
      hi      = 32'(h);
      ni      = 0;
      w_pa    = word[PAW-1:0];
      hi_mask = ONES << (ti + 5);
      base    = w_pa & hi_mask;
      tag_eq  = ((w_pa ^ pa) & hi_mask) == '0;
      idx     = '0;
      act     = ACT_FAULT;
      kind    = FK_PTR;
      perm    = 3'b000;
      addr    = '0;
      sub     = '0;
      h_next  = h;
      if (nap_found && (ti + 5 <= PAW) && (hi <= PAW)) begin
         case (word[3:0])
            4'd0: act = ACT_LEAF;
            4'd1, 4'd3, 4'd4, 4'd5, 4'd7: begin
               if (tag_eq) begin
                  act  = ACT_LEAF;
                  perm = word[2:0];
               end
            end
            4'd2: begin
               if (hi >= H_FLOOR + ti) begin
                  idx    = (pa >> (hi - ti)) & ~(ONES << ti);
                  addr   = base | (idx << 3);
                  h_next = h - HW'(ti);
                  act    = ACT_FETCH;
                  kind   = FK_PTR;
               end
            end
            4'd6: begin
               ni = ti + 6;
               if (hi >= H_FLOOR + ni) begin
                  idx  = (pa >> (hi - ni)) & ~(ONES << ni);
                  addr = base | ((idx >> 4) << 3);
                  sub  = {1'b0, idx[3:0]};
                  act  = ACT_FETCH;
                  kind = FK_NIB;
               end
            end
            4'd14: begin
               ni = ti + 7;
               if (hi >= H_FLOOR + ni) begin
                  idx  = (pa >> (hi - ni)) & ~(ONES << ni);
                  addr = base | ((idx >> 5) << 3);
                  sub  = idx[4:0];
                  act  = ACT_FETCH;
                  kind = FK_PAIR;
               end
            end
            default: act = ACT_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/mlat_pick.sv
module mlat_pick
   import mlat_pkg::*;
(
   input  mlat_kind_e  kind,
   input  logic [63:0] dw,
   input  logic [4:0]  sub,
   output logic        fault,
   output logic [2:0]  perm
);

   localparam int NNIB  = 16;
   localparam int NPAIR = 32;

   logic [3:0] nib_lane  [NNIB];
   logic [1:0] pair_lane [NPAIR];

   for (genvar g = 0; g < NNIB; g++) begin : g_nib
      assign nib_lane[g] = dw[4*g +: 4];
   end

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      assign pair_lane[g] = dw[2*g +: 2];
   end

   logic [3:0] nib_sel;
   logic [1:0] pair_sel;

   always_comb begin
      nib_sel  = nib_lane[sub[3:0]];
      pair_sel = pair_lane[sub];
      fault    = 1'b0;
      perm     = 3'b000;
      if (kind == FK_PAIR) begin
         perm = pair_to_perm(pair_sel);
      end else if (nib_is_leaf(nib_sel)) begin
         perm = nib_sel[2:0];
      end else begin
         fault = 1'b1;
      end
   end

endmodule

// File: rtl/mlat_walker.sv
module mlat_walker
   import mlat_pkg::*;
#(
   parameter int PAW       = 40,
   parameter int MAX_DEPTH = 3,
   parameter int SW        = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_valid,
   output logic           start_ready,
   input  logic [63:0]    start_ptr,
   input  logic [SW-1:0]  start_s,
   input  logic [PAW-1:0] start_pa,
   output logic           mem_req_valid,
   input  logic           mem_req_ready,
   output logic [PAW-1:0] mem_req_addr,
   input  logic           mem_rsp_valid,
   input  logic [63:0]    mem_rsp_data,
   output logic           done_valid,
   output logic           done_fault,
   output logic [2:0]     done_perm
);

   localparam int HW  = $clog2(H_FLOOR + (1 << SW));
   localparam int DPW = $clog2(MAX_DEPTH + 1);

   if (PAW < 24 || PAW > 64) begin : g_bad_paw
      $error("mlat_walker: PAW must lie in 24..64");
   end
   if (MAX_DEPTH < 1) begin : g_bad_depth
      $error("mlat_walker: MAX_DEPTH must be at least 1");
   end
   if (SW < 1 || SW > 6) begin : g_bad_sw
      $error("mlat_walker: SW must lie in 1..6");
   end

   mlat_state_e    state;
   logic [63:0]    cur_word;
   logic [HW-1:0]  cur_h;
   logic [PAW-1:0] pa_q;
   logic [DPW-1:0] depth;
   logic [PAW-1:0] req_addr_q;
   mlat_kind_e     kind_q;
   logic [4:0]     sub_q;

   mlat_act_e      dec_act;
   mlat_kind_e     dec_kind;
   logic [2:0]     dec_perm;
   logic [PAW-1:0] dec_addr;
   logic [4:0]     dec_sub;
   logic [HW-1:0]  dec_h_next;

   mlat_decode #(.PAW(PAW), .HW(HW)) i_decode (
      .word   (cur_word),
      .h      (cur_h),
      .pa     (pa_q),
      .act    (dec_act),
      .kind   (dec_kind),
      .perm   (dec_perm),
      .addr   (dec_addr),
      .sub    (dec_sub),
      .h_next (dec_h_next)
   );

   logic       pick_fault;
   logic [2:0] pick_perm;

   mlat_pick i_pick (
      .kind  (kind_q),
      .dw    (mem_rsp_data),
      .sub   (sub_q),
      .fault (pick_fault),
      .perm  (pick_perm)
   );

   logic depth_full;
   assign depth_full = (depth == DPW'(MAX_DEPTH));

   assign start_ready   = (state == WS_IDLE);
   assign mem_req_valid = (state == WS_REQ);
   assign mem_req_addr  = req_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= WS_IDLE;
         cur_word   <= '0;
         cur_h      <= '0;
         pa_q       <= '0;
         depth      <= '0;
         req_addr_q <= '0;
         kind_q     <= FK_PTR;
         sub_q      <= '0;
         done_valid <= 1'b0;
         done_fault <= 1'b0;
         done_perm  <= 3'b000;
      end else begin
         done_valid <= 1'b0;
         done_fault <= 1'b0;
         done_perm  <= 3'b000;
         case (state)
            WS_IDLE: begin
               if (start_valid) begin
                  cur_word <= start_ptr;
                  cur_h    <= HW'(H_FLOOR) + HW'(start_s);
                  pa_q     <= start_pa;
                  depth    <= '0;
                  state    <= WS_EVAL;
               end
            end
            WS_EVAL: begin
               if (dec_act == ACT_LEAF) begin
                  done_valid <= 1'b1;
                  done_perm  <= dec_perm;
                  state      <= WS_IDLE;
               end else if (dec_act == ACT_FAULT ||
                            (dec_kind == FK_PTR && depth_full)) begin
                  done_valid <= 1'b1;
                  done_fault <= 1'b1;
                  state      <= WS_IDLE;
               end else begin
                  req_addr_q <= dec_addr;
                  kind_q     <= dec_kind;
                  sub_q      <= dec_sub;
                  if (dec_kind == FK_PTR) begin
                     cur_h <= dec_h_next;
                     depth <= depth + 1'b1;
                  end
                  state <= WS_REQ;
               end
            end
            WS_REQ: begin
               if (mem_req_ready) state <= WS_WAIT;
            end
            WS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (kind_q == FK_PTR) begin
                     cur_word <= mem_rsp_data;
                     state    <= WS_EVAL;
                  end else begin
                     done_valid <= 1'b1;
                     done_fault <= pick_fault;
                     done_perm  <= pick_fault ? 3'b000 : pick_perm;
                     state      <= WS_IDLE;
                  end
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mlat_walker_chk.sv
module mlat_walker_chk #(
   parameter int PAW       = 40,
   parameter int MAX_DEPTH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_valid,
   input logic           start_ready,
   input logic           mem_req_valid,
   input logic           mem_req_ready,
   input logic [PAW-1:0] mem_req_addr,
   input logic           mem_rsp_valid,
   input logic           done_valid,
   input logic           done_fault,
   input logic [2:0]     done_perm
);

   logic pend;
   int   walk_reqs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         walk_reqs <= 0;
      end else begin
         if (mem_req_valid && mem_req_ready) pend <= 1'b1;
         else if (mem_rsp_valid)             pend <= 1'b0;
         if (start_valid && start_ready)         walk_reqs <= 0;
         else if (mem_req_valid && mem_req_ready) walk_reqs <= walk_reqs + 1;
      end
   end

   a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

   a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !pend);

   a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !start_ready);

   a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   a_r12_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_fault |-> done_perm == 3'b000);

   a_r10_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
      walk_reqs <= MAX_DEPTH + 1);

endmodule

bind mlat_walker mlat_walker_chk #(.PAW(PAW), .MAX_DEPTH(MAX_DEPTH)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_valid   (start_valid),
   .start_ready   (start_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_rsp_valid (mem_rsp_valid),
   .done_valid    (done_valid),
   .done_fault    (done_fault),
   .done_perm     (done_perm)
);

// File: tb/test_mlat_walker.sv
module test_mlat_walker;

   localparam int CLK_PERIOD = 10;
   localparam int PAW = 40;
   localparam int MAXD = 3;
   localparam int SW = 6;
   localparam logic [39:0] PA = 40'h12_3456_7890;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_valid = 1'b0;
   logic           start_ready;
   logic [63:0]    start_ptr = '0;
   logic [SW-1:0]  start_s = '0;
   logic [PAW-1:0] start_pa = '0;
   logic           mem_req_valid;
   logic           mem_req_ready = 1'b0;
   logic [PAW-1:0] mem_req_addr;
   logic           mem_rsp_valid = 1'b0;
   logic [63:0]    mem_rsp_data = '0;
   logic           done_valid;
   logic           done_fault;
   logic [2:0]     done_perm;

   always #(CLK_PERIOD/2) clk = ~clk;

   mlat_walker #(.PAW(PAW), .MAX_DEPTH(MAXD), .SW(SW)) i_mlat_walker (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_ptr(start_ptr), .start_s(start_s), .start_pa(start_pa),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
      .done_fault(done_fault), .done_perm(done_perm)
   );

   int total = 0;
   int bad = 0;
   logic [63:0] mem [longint unsigned];
   int req_cnt = 0;
   logic [PAW-1:0] req_log [8];
   int pace = 0;

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [63:0] mkw(input int typ, input int t, input logic [63:0] a);
      logic [63:0] m;
      m = ~64'd0 << (t + 5);
      return (a & m) | (64'd1 << (4 + t)) | 64'(typ);
   endfunction

   function automatic logic [63:0] pbits(input int h, input int n);
      return (64'(PA) >> (h - n)) & ~(~64'd0 << n);
   endfunction

   // memory responder: stalls ready and varies response latency
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            repeat (pace % 3) @(negedge clk);
            if (req_cnt < 8) req_log[req_cnt] = mem_req_addr;
            req_cnt++;
            mem_rsp_data = mem.exists(longint'(mem_req_addr)) ? mem[longint'(mem_req_addr)] : 64'd0;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (pace % 2) @(negedge clk);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            pace++;
         end
      end
   end

   task automatic walk(input logic [63:0] ptr, input int s,
                       output logic flt, output logic [2:0] pm, output int nreq);
      int guard;
      req_cnt = 0;
      @(negedge clk);
      start_valid = 1'b1; start_ptr = ptr; start_s = SW'(s); start_pa = PA;
      @(negedge clk);
      start_valid = 1'b0;
      check("R1 busy after accept", 64'(start_ready), 64'd0);
      guard = 0;
      while (!done_valid && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      check("R12 result arrives", 64'(done_valid), 64'd1);
      flt = done_fault; pm = done_perm; nreq = req_cnt;
      @(negedge clk);
      check("R12 one-cycle pulse", 64'(done_valid), 64'd0);
      check("R1 ready after walk", 64'(start_ready), 64'd1);
   endtask

   task automatic t_reset;
      check("R1 reset start_ready", 64'(start_ready), 64'd1);
      check("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      check("R1 reset done_valid", 64'(done_valid), 64'd0);
   endtask

   task automatic t_leaves;
      logic f; logic [2:0] p; int n;
      walk(mkw(3, 0, 64'(PA)), 20, f, p, n);
      check("R3 type3 fault", 64'(f), 0); check("R3 type3 perm", 64'(p), 64'b011);
      check("R3 no read", 64'(n), 0);
      walk(mkw(4, 2, 64'(PA)), 20, f, p, n);
      check("R3 type4 perm", 64'(p), 64'b100);
      walk(mkw(0, 0, 64'h5555_0000), 20, f, p, n);
      check("R4 type0 no tag check", {f, p}, 64'b0000);
      walk(mkw(7, 0, 64'(PA) ^ 64'h100), 20, f, p, n);
      check("R4 tag mismatch fault", 64'(f), 1);
      walk(mkw(5, 0, 64'(PA) ^ 64'h10), 20, f, p, n);
      check("R4 bit below 5+T ignored", {f, p}, 64'b0101);
   endtask

   task automatic t_malformed;
      logic f; logic [2:0] p; int n;
      walk(64'h9 | 64'h10, 20, f, p, n);
      check("R8 reserved type 9", 64'(f), 1); check("R8 no read", 64'(n), 0);
      walk(64'hF | 64'h10, 20, f, p, n);
      check("R8 reserved type 15", 64'(f), 1);
      walk(64'h3, 20, f, p, n);
      check("R2 empty NAPOT field", 64'(f), 1);
      walk(mkw(3, 0, 64'(PA)), 40, f, p, n);
      check("R2 H above PAW", 64'(f), 1);
   endtask

   task automatic t_two_level;
      logic f; logic [2:0] p; int n;
      logic [63:0] a;
      a = 64'h10_0000 | (pbits(30, 9) << 3);
      mem[longint'(a)] = mkw(5, 0, 64'(PA));
      walk(mkw(2, 9, 64'h10_0000), 18, f, p, n);
      check("R5 one read", 64'(n), 1);
      check("R5 fetch address", 64'(req_log[0]), a);
      check("R5 leaf from memory", {f, p}, 64'b0101);
   endtask

   task automatic t_nibble;
      logic f; logic [2:0] p; int n;
      logic [63:0] idx, a;
      int k;
      idx = pbits(22, 8);
      a = 64'h8000 | ((idx >> 4) << 3);
      k = int'(idx[3:0]);
      mem[longint'(a)] = (64'h3333_3333_3333_3333 & ~(64'hF << (4*k))) | (64'h7 << (4*k));
      walk(mkw(6, 2, 64'h8000), 10, f, p, n);
      check("R6 fetch address", 64'(req_log[0]), a);
      check("R6 nibble perm", {f, p}, 64'b0111);
      mem[longint'(a)] = (64'h3333_3333_3333_3333 & ~(64'hF << (4*k))) | (64'h6 << (4*k));
      walk(mkw(6, 2, 64'h8000), 10, f, p, n);
      check("R6 nibble 6 faults", 64'(f), 1);
   endtask

   task automatic t_pair;
      logic f; logic [2:0] p; int n;
      logic [63:0] idx, a;
      int k;
      idx = pbits(24, 7);
      a = 64'hA000 | ((idx >> 5) << 3);
      k = int'(idx[4:0]);
      mem[longint'(a)] = ~(64'h3 << (2*k)) | (64'h2 << (2*k));
      walk(mkw(14, 0, 64'hA000), 12, f, p, n);
      check("R7 fetch address", 64'(req_log[0]), a);
      check("R7 pair 2 perm", {f, p}, 64'b0101);
      mem[longint'(a)] = ~(64'h3 << (2*k)) | (64'h1 << (2*k));
      walk(mkw(14, 0, 64'hA000), 12, f, p, n);
      check("R7 pair 1 perm", {f, p}, 64'b0001);
   endtask

   task automatic t_small_region;
      logic f; logic [2:0] p; int n;
      walk(mkw(6, 2, 64'h8000), 5, f, p, n);
      check("R9 last-level under 4K", 64'(f), 1); check("R9 no read", 64'(n), 0);
      walk(mkw(2, 1, 64'h8000), 0, f, p, n);
      check("R9 pointer under 4K", 64'(f), 1);
   endtask

   task automatic t_depth;
      logic f; logic [2:0] p; int n;
      logic [63:0] a1, a2, a3;
      a1 = 64'h2000 | (pbits(40, 4) << 3);
      a2 = 64'h4000 | (pbits(36, 4) << 3);
      a3 = 64'h6000 | (pbits(32, 4) << 3);
      mem[longint'(a1)] = mkw(2, 4, 64'h4000);
      mem[longint'(a2)] = mkw(2, 4, 64'h6000);
      mem[longint'(a3)] = mkw(2, 4, 64'hC000);
      walk(mkw(2, 4, 64'h2000), 28, f, p, n);
      check("R10 depth exceeded fault", 64'(f), 1);
      check("R10 reads stop at limit", 64'(n), MAXD);
      check("R11 third address", 64'(req_log[2]), a3);
      mem[longint'(a3)] = mkw(1, 0, 64'(PA));
      walk(mkw(2, 4, 64'h2000), 28, f, p, n);
      check("R10 full depth leaf", {f, p}, 64'b0001);
   endtask

   initial begin
      int cyc = 0;
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset;
            t_leaves;
            t_malformed;
            t_two_level;
            t_nibble;
            t_pair;
            t_small_region;
            t_depth;
         end
         begin
            while (cyc < 50000) begin
               @(posedge clk);
               cyc++;
            end
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule